// File: doc/BRIEF.md
# Test Pattern Assembly Sequencer

This block sits between a slow external tester and a fast circuit under test. Its job is to deliver complete test vectors at the fast clock rate, even though the tester can only supply data slowly.

Test vectors are grouped into partitions. Within a partition, every vector shares one common field, and that field is a repetition of a short representative piece. For each partition, the tester shifts that piece in over a narrow port, one pin-width word per slow tick. The block then rebuilds each vector of the partition from two sources:

- the stored piece, repeated across the common field, whose offset and width are set per partition;
- the distinct bits, taken from a word read out of pattern memory at the partition's base address plus the vector index.

The finished vectors leave back to back, one per fast cycle.

A fixed schedule, given as an input, lists the partitions in the order they are sent; a partition may appear more than once. Two piece buffers are used alternately. While the vectors of one schedule entry stream out of one buffer, the tester can already load the next entry into the other buffer. A load into a buffer that still holds an unsent entry waits until that entry has been sent. After the last vector of the last schedule entry, a single-cycle done pulse marks the end of the run.

All logic runs on the fast clock. The slow tester rate appears only as a one-cycle tick input, repeating every p fast cycles, where p is the integer clock ratio.

Top module: `tpat_assembler`

## Requirements
- R1: While reset is held and until the first start, `vecValid`, `done` and `tstReq` are 0.
- R2: A schedule entry whose partition has a piece length of c bits takes exactly ceil(c/PIN_W) tester words. Word k fills piece bits [k*PIN_W +: PIN_W]. A word is taken only on a cycle in which both `tstReq` and `slowTick` are 1.
- R3: For a vector of a partition with field offset o, field width L and piece length c, each output bit i with o <= i < o+L equals piece bit (i-o) mod c.
- R4: Every output bit outside the common field equals the matching bit of the pattern memory word. For vector v of the partition, that word is read at address (base + v) mod 2^ADDR_W.
- R5: The vectors of one schedule entry leave in consecutive cycles with `vecValid` high, in index order 0 to count-1.
- R6: Schedule entries are sent in schedule order. Exactly the sum of their vector counts is output, and no other vectors are.
- R7: No vector of a schedule entry is output before the last tester word of that entry has been taken.
- R8: Loading of entry k+2 does not take its first word until every vector of entry k has been output. The loader never requests words into a buffer that still holds an unsent entry.
- R9: Loading of entry k+1 may proceed while entry k is being sent: tester words are taken on cycles in which `vecValid` is high.
- R10: `done` is high for exactly one cycle per run, in the cycle right after the last vector of the last schedule entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run of the schedule; ignored while a run is in progress |
| slowTick | input | 1 | One-cycle pulse per slow tester cycle |
| tstData | input | PIN_W | Tester word, taken when `slowTick` and `tstReq` are both high |
| tstReq | output | 1 | The loader is waiting for piece words |
| schedPart | input | SCHED_LEN*PIDX_W | Partition index of each schedule entry; entry e sits in bits [e*PIDX_W +: PIDX_W] |
| descCount | input | NPART*CNT_W | Vector count per partition (at least 1) |
| descOffset | input | NPART*OFF_W | Bit offset of the common field per partition |
| descWidth | input | NPART*LEN_W | Width of the common field per partition |
| descRepLen | input | NPART*REP_W | Piece length c per partition, 1 to REP_MAX |
| descBase | input | NPART*ADDR_W | Pattern memory base address per partition |
| distAddr | output | ADDR_W | Pattern memory read address |
| distData | input | VEC_W | Pattern memory word at `distAddr`, combinational read |
| vecValid | output | 1 | `vecData` holds a finished vector |
| vecData | output | VEC_W | Finished test vector |
| done | output | 1 | End-of-run pulse |

## Verification
The assertions rely on several properties of the inputs:

- every piece length lies between 1 and REP_MAX;
- every vector count is at least 1;
- each common field fits inside the vector;
- `slowTick` is a single-cycle pulse;
- `start` arrives only when the block is idle;
- the descriptors stay constant during a run.

The stimulus derives every run's descriptors arithmetically from the run number, keeping each of these properties by construction. It also steps the clock ratio from 1 to 4 and rotates the schedule, so that repeated partitions, short and long pieces, and fields at both edges of the vector all occur.

// File: rtl/tpa_pkg.sv
`timescale 1ns/1ps
package tpa_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // latch descriptor of the entry about to load
    logic writeWord;  // store one tester word into the loading buffer
    logic ldBuf;      // buffer being loaded
    logic issue;      // issue one vector read this cycle
    logic sendBuf;    // buffer being sent
    logic issueFinal; // this issue is the last vector of the schedule
  } tpa_strobe_t;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_ARM  = 2'd1,
    LD_FILL = 2'd2
  } ld_state_e;

endpackage

// File: rtl/tpa_ctrl.sv
`timescale 1ns/1ps
module tpa_ctrl import tpa_pkg::*; #(
  parameter int SCHED_LEN = 4,
  localparam int SIDX_W = $clog2(SCHED_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              slowTick,
  input  logic              ldLastWord,
  input  logic              sendLastVec,
  output tpa_strobe_t       st,
  output logic              tstReq,
  output logic [SIDX_W-1:0] ldIdx
);

  localparam logic [SIDX_W-1:0] LAST_ENTRY = SIDX_W'(SCHED_LEN - 1);

  ld_state_e         ldState;
  logic [1:0]        bufValid;
  logic [1:0]        setValid;
  logic [1:0]        clrValid;
  logic [SIDX_W-1:0] sendIdx;
  logic              ldBuf;
  logic              sendBuf;
  logic              running;
  logic              idleAll;
  logic              loadDone;
  logic              sendDone;

  assign idleAll  = (ldState == LD_IDLE) && !running;
  assign tstReq   = (ldState == LD_FILL);
  assign loadDone = st.writeWord && ldLastWord;
  assign sendDone = st.issue && sendLastVec;

  always_comb begin
    st            = '0;
    st.ldBuf      = ldBuf;
    st.sendBuf    = sendBuf;
    st.capture    = (ldState == LD_ARM) && !bufValid[ldBuf];
    st.writeWord  = (ldState == LD_FILL) && slowTick;
    st.issue      = running && bufValid[sendBuf];
    st.issueFinal = st.issue && sendLastVec && (sendIdx == LAST_ENTRY);
  end

  always_comb begin
    setValid = '0;
    clrValid = '0;
    if (loadDone) setValid[ldBuf]   = 1'b1;
    if (sendDone) clrValid[sendBuf] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldState  <= LD_IDLE;
      bufValid <= '0;
      ldIdx    <= '0;
      sendIdx  <= '0;
      ldBuf    <= 1'b0;
      sendBuf  <= 1'b0;
      running  <= 1'b0;
    end else if (start && idleAll) begin
      ldState  <= LD_ARM;
      bufValid <= '0;
      ldIdx    <= '0;
      sendIdx  <= '0;
      ldBuf    <= 1'b0;
      sendBuf  <= 1'b0;
      running  <= 1'b1;
    end else begin
      bufValid <= (bufValid & ~clrValid) | setValid;
      case (ldState)
        LD_ARM:  if (st.capture) ldState <= LD_FILL;
        LD_FILL: if (loadDone) begin
          ldBuf   <= ~ldBuf;
          ldIdx   <= ldIdx + 1'b1;
          ldState <= (ldIdx == LAST_ENTRY) ? LD_IDLE : LD_ARM;
        end
        default: ldState <= LD_IDLE;
      endcase
      if (sendDone) begin
        sendBuf <= ~sendBuf;
        sendIdx <= sendIdx + 1'b1;
        if (sendIdx == LAST_ENTRY) running <= 1'b0;
      end
    end
  end

  // R8: words are only requested into a buffer that holds no unsent entry
  assert_fill_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    tstReq |-> !bufValid[ldBuf]);

  // R7: an entry is only sent once its load has completed
  assert_send_loaded_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.issue |-> (sendIdx < ldIdx));

endmodule

// File: rtl/tpa_dpath.sv
`timescale 1ns/1ps
module tpa_dpath import tpa_pkg::*; #(
  parameter int VEC_W     = 16,
  parameter int PIN_W     = 2,
  parameter int REP_MAX   = 8,
  parameter int NPART     = 4,
  parameter int SCHED_LEN = 4,
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = 6,
  localparam int OFF_W   = $clog2(VEC_W),
  localparam int LEN_W   = $clog2(VEC_W + 1),
  localparam int REP_W   = $clog2(REP_MAX + 1),
  localparam int WORDS   = (REP_MAX + PIN_W - 1) / PIN_W,
  localparam int PIECE_W = WORDS * PIN_W,
  localparam int PTR_W   = $clog2(WORDS + 1),
  localparam int PIDX_W  = (NPART > 1) ? $clog2(NPART) : 1,
  localparam int SIDX_W  = $clog2(SCHED_LEN + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tpa_strobe_t                 st,
  input  logic [SIDX_W-1:0]           ldIdx,
  input  logic [SCHED_LEN*PIDX_W-1:0] schedPart,
  input  logic [NPART*CNT_W-1:0]      descCount,
  input  logic [NPART*OFF_W-1:0]      descOffset,
  input  logic [NPART*LEN_W-1:0]      descWidth,
  input  logic [NPART*REP_W-1:0]      descRepLen,
  input  logic [NPART*ADDR_W-1:0]     descBase,
  input  logic [PIN_W-1:0]            tstData,
  input  logic [VEC_W-1:0]            distData,
  output logic                        ldLastWord,
  output logic                        sendLastVec,
  output logic [ADDR_W-1:0]           distAddr,
  output logic                        vecValid,
  output logic [VEC_W-1:0]            vecData,
  output logic                        done
);

  // Per-buffer piece and latched descriptor
  logic [PIECE_W-1:0] piece [2];
  logic [CNT_W-1:0]   dCnt  [2];
  logic [OFF_W-1:0]   dOff  [2];
  logic [LEN_W-1:0]   dLen  [2];
  logic [REP_W-1:0]   dRep  [2];
  logic [ADDR_W-1:0]  dBase [2];

  logic [PIDX_W-1:0]  ldPart;
  logic [CNT_W-1:0]   selCnt;
  logic [OFF_W-1:0]   selOff;
  logic [LEN_W-1:0]   selLen;
  logic [REP_W-1:0]   selRep;
  logic [ADDR_W-1:0]  selBase;
  logic [PTR_W-1:0]   ptr;
  logic [CNT_W-1:0]   vecIdx;
  logic               rdVal;
  logic               rdBuf;
  logic               rdFinal;
  logic               vecFinal;
  logic [VEC_W-1:0]   merged;

  // Partition of the entry being loaded
  always_comb begin
    ldPart = '0;
    for (int e = 0; e < SCHED_LEN; e++)
      if (int'(ldIdx) == e) ldPart = schedPart[e*PIDX_W +: PIDX_W];
  end

  // Descriptor of that partition
  always_comb begin
    selCnt  = '0;
    selOff  = '0;
    selLen  = '0;
    selRep  = '0;
    selBase = '0;
    for (int q = 0; q < NPART; q++) begin
      if (int'(ldPart) == q) begin
        selCnt  = descCount [q*CNT_W  +: CNT_W];
        selOff  = descOffset[q*OFF_W  +: OFF_W];
        selLen  = descWidth [q*LEN_W  +: LEN_W];
        selRep  = descRepLen[q*REP_W  +: REP_W];
        selBase = descBase  [q*ADDR_W +: ADDR_W];
      end
    end
  end

  // Load side: descriptor capture and piece word writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        piece[b] <= '0;
        dCnt[b]  <= '0;
        dOff[b]  <= '0;
        dLen[b]  <= '0;
        dRep[b]  <= '0;
        dBase[b] <= '0;
      end
      ptr <= '0;
    end else begin
      if (st.capture) begin
        dCnt[st.ldBuf]  <= selCnt;
        dOff[st.ldBuf]  <= selOff;
        dLen[st.ldBuf]  <= selLen;
        dRep[st.ldBuf]  <= selRep;
        dBase[st.ldBuf] <= selBase;
        ptr             <= '0;
      end else if (st.writeWord) begin
        piece[st.ldBuf][int'(ptr)*PIN_W +: PIN_W] <= tstData;
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign ldLastWord  = ((int'(ptr) + 1) * PIN_W) >= int'(dRep[st.ldBuf]);
  assign sendLastVec = (int'(vecIdx) + 1) >= int'(dCnt[st.sendBuf]);

  // Send stage 1: read address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecIdx   <= '0;
      distAddr <= '0;
      rdVal    <= 1'b0;
      rdBuf    <= 1'b0;
      rdFinal  <= 1'b0;
    end else begin
      rdVal   <= st.issue;
      rdFinal <= st.issueFinal;
      if (st.issue) begin
        distAddr <= dBase[st.sendBuf] + ADDR_W'(vecIdx);
        rdBuf    <= st.sendBuf;
        vecIdx   <= sendLastVec ? '0 : vecIdx + 1'b1;
      end
    end
  end

  // Replicate the piece over the common field, keep stored bits elsewhere
  always_comb begin
    int rel;
    int repN;
    repN = (dRep[rdBuf] == '0) ? 1 : int'(dRep[rdBuf]);
    for (int i = 0; i < VEC_W; i++) begin
      rel = i - int'(dOff[rdBuf]);
      if (rel >= 0 && rel < int'(dLen[rdBuf]))
        merged[i] = piece[rdBuf][rel % repN];
      else
        merged[i] = distData[i];
    end
  end

  // Send stage 2: finished vector and end pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecData  <= '0;
      vecFinal <= 1'b0;
      done     <= 1'b0;
    end else begin
      vecValid <= rdVal;
      vecFinal <= rdVal && rdFinal;
      if (rdVal) vecData <= merged;
      done <= vecValid && vecFinal;
    end
  end

  // R2: no word lands beyond the piece storage
  assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.writeWord |-> (int'(ptr) < WORDS));

  // R5: within an entry, read addresses advance by one every cycle
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(st.issue) && $past(st.issue, 2) && !$past(sendLastVec, 2))
      |-> (distAddr == ADDR_W'($past(distAddr) + 1'b1)));

  // R10: the end pulse lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/tpat_assembler.sv
`timescale 1ns/1ps
module tpat_assembler import tpa_pkg::*; #(
  parameter int VEC_W     = 16,
  parameter int PIN_W     = 2,
  parameter int REP_MAX   = 8,
  parameter int NPART     = 4,
  parameter int SCHED_LEN = 4,
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = 6,
  localparam int OFF_W  = $clog2(VEC_W),
  localparam int LEN_W  = $clog2(VEC_W + 1),
  localparam int REP_W  = $clog2(REP_MAX + 1),
  localparam int PIDX_W = (NPART > 1) ? $clog2(NPART) : 1,
  localparam int SIDX_W = $clog2(SCHED_LEN + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        slowTick,
  input  logic [PIN_W-1:0]            tstData,
  output logic                        tstReq,
  input  logic [SCHED_LEN*PIDX_W-1:0] schedPart,
  input  logic [NPART*CNT_W-1:0]      descCount,
  input  logic [NPART*OFF_W-1:0]      descOffset,
  input  logic [NPART*LEN_W-1:0]      descWidth,
  input  logic [NPART*REP_W-1:0]      descRepLen,
  input  logic [NPART*ADDR_W-1:0]     descBase,
  output logic [ADDR_W-1:0]           distAddr,
  input  logic [VEC_W-1:0]            distData,
  output logic                        vecValid,
  output logic [VEC_W-1:0]            vecData,
  output logic                        done
);

  tpa_strobe_t       st;
  logic              ldLastWord;
  logic              sendLastVec;
  logic [SIDX_W-1:0] ldIdx;

  tpa_ctrl #(.SCHED_LEN(SCHED_LEN)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .slowTick    (slowTick),
    .ldLastWord  (ldLastWord),
    .sendLastVec (sendLastVec),
    .st          (st),
    .tstReq      (tstReq),
    .ldIdx       (ldIdx)
  );

  tpa_dpath #(
    .VEC_W(VEC_W), .PIN_W(PIN_W), .REP_MAX(REP_MAX), .NPART(NPART),
    .SCHED_LEN(SCHED_LEN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .ldIdx       (ldIdx),
    .schedPart   (schedPart),
    .descCount   (descCount),
    .descOffset  (descOffset),
    .descWidth   (descWidth),
    .descRepLen  (descRepLen),
    .descBase    (descBase),
    .tstData     (tstData),
    .distData    (distData),
    .ldLastWord  (ldLastWord),
    .sendLastVec (sendLastVec),
    .distAddr    (distAddr),
    .vecValid    (vecValid),
    .vecData     (vecData),
    .done        (done)
  );

endmodule

// File: tb/tpat_assembler_bench.sv
`timescale 1ns/1ps
module tpat_assembler_bench;

  localparam int VW = 16;
  localparam int NP = 4;
  localparam int NS = 4;
  localparam int RUNS = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        slowTick = 1'b0;
  logic [1:0]  tstData = 2'b11;
  logic        tstReq;
  logic [7:0]  schedPart;
  logic [15:0] descCount;
  logic [15:0] descOffset;
  logic [19:0] descWidth;
  logic [15:0] descRepLen;
  logic [23:0] descBase;
  logic [5:0]  distAddr;
  logic [15:0] distData;
  logic        vecValid;
  logic [15:0] vecData;
  logic        done;

  always #4 clk = ~clk;

  tpat_assembler u_tpat_assembler (
    .clk(clk), .rstN(rstN), .start(start), .slowTick(slowTick),
    .tstData(tstData), .tstReq(tstReq), .schedPart(schedPart),
    .descCount(descCount), .descOffset(descOffset), .descWidth(descWidth),
    .descRepLen(descRepLen), .descBase(descBase), .distAddr(distAddr),
    .distData(distData), .vecValid(vecValid), .vecData(vecData), .done(done)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  int runIdx, p;
  int cnt[NP], off[NP], len[NP], rep[NP], base[NP], sched[NS];

  // monitor state
  bit monOn = 1'b0;
  int cyc, tickCnt, ldE, wTaken, sndE, sndV, lastVecCyc, doneCount;
  int sentCnt[NS];
  bit loadDone[NS];
  bit overlapSeen;

  function automatic logic [15:0] patWord(logic [5:0] a);
    logic [15:0] t;
    t = {10'd0, a} * 16'd40503;
    return t ^ 16'hA5C3;
  endfunction

  function automatic logic [1:0] tword(int e, int w);
    return 2'((runIdx * 7 + e * 5 + w * 3 + 1) % 4);
  endfunction

  function automatic logic pieceBit(int e, int k);
    logic [1:0] t;
    t = tword(e, k / 2);
    return t[k % 2];
  endfunction

  function automatic int needWords(int e);
    return (rep[sched[e]] + 1) / 2;
  endfunction

  function automatic logic [15:0] fieldMask(int q);
    logic [15:0] m = '0;
    for (int i = 0; i < VW; i++)
      if (i >= off[q] && i < off[q] + len[q]) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] expVec(int e, int v);
    int q = sched[e];
    logic [15:0] m = patWord(6'((base[q] + v) % 64));
    for (int i = 0; i < VW; i++)
      if (i >= off[q] && i < off[q] + len[q])
        m[i] = pieceBit(e, (i - off[q]) % rep[q]);
    return m;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (run %0d, cycle %0d)", req, act, exp, runIdx, cyc);
    end
  endtask

  assign distData = patWord(distAddr);

  always_comb begin
    for (int q = 0; q < NP; q++) begin
      descCount [q*4 +: 4] = 4'(cnt[q]);
      descOffset[q*4 +: 4] = 4'(off[q]);
      descWidth [q*5 +: 5] = 5'(len[q]);
      descRepLen[q*4 +: 4] = 4'(rep[q]);
      descBase  [q*6 +: 6] = 6'(base[q]);
    end
    for (int e = 0; e < NS; e++) schedPart[e*2 +: 2] = 2'(sched[e]);
  end

  // Monitor and tester model, all at the falling edge
  always @(negedge clk) begin
    if (monOn) begin
      bit tickNow;
      logic [15:0] exp, msk;
      cyc++;
      // vectors
      if (vecValid) begin
        if (sndE >= NS) begin
          check(1'b0, "R6 extra vector", vecData, 0);
        end else begin
          check(loadDone[sndE], "R7 vector before load complete", 0, 1);
          exp = expVec(sndE, sndV);
          msk = fieldMask(sched[sndE]);
          check((vecData & msk) == (exp & msk), "R3 common field", vecData & msk, exp & msk);
          check((vecData & ~msk) == (exp & ~msk), "R4,R6 distinct bits", vecData & ~msk, exp & ~msk);
          sentCnt[sndE]++;
          sndV++;
          if (sndV == cnt[sched[sndE]]) begin
            sndE++;
            sndV = 0;
            lastVecCyc = cyc;
          end
        end
      end else if (sndV > 0) begin
        check(1'b0, "R5 gap inside entry", 0, 1);
      end
      // done
      if (done) begin
        doneCount++;
        check(cyc == lastVecCyc + 1 && sndE == NS, "R10 done timing", cyc, lastVecCyc + 1);
      end
      // tester
      tickNow = (tickCnt == p - 1);
      tickCnt = tickNow ? 0 : tickCnt + 1;
      slowTick = tickNow;
      tstData = 2'b11;
      if (tickNow && tstReq) begin
        if (ldE >= NS) begin
          check(1'b0, "R2 extra word requested", ldE, NS - 1);
        end else begin
          if (wTaken == 0 && ldE >= 2)
            check(sentCnt[ldE-2] == cnt[sched[ldE-2]], "R8 load before release",
                  sentCnt[ldE-2], cnt[sched[ldE-2]]);
          if (vecValid) overlapSeen = 1'b1;
          tstData = tword(ldE, wTaken);
          wTaken++;
          if (wTaken == needWords(ldE)) begin
            loadDone[ldE] = 1'b1;
            ldE++;
            wTaken = 0;
          end
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    for (int q = 0; q < NP; q++) begin
      cnt[q] = 1; off[q] = 0; len[q] = 1; rep[q] = 1; base[q] = 0;
    end
    for (int e = 0; e < NS; e++) sched[e] = 0;
    runIdx = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(vecValid == 1'b0, "R1 vecValid in reset", vecValid, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(tstReq == 1'b0, "R1 tstReq in reset", tstReq, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(vecValid == 1'b0 && done == 1'b0 && tstReq == 1'b0, "R1 idle after reset",
          {vecValid, done, tstReq}, 0);

    for (int r = 0; r < RUNS; r++) begin
      int waitCyc;
      runIdx = r;
      p = (r == 0) ? 2 : 1 + (r % 4);
      for (int q = 0; q < NP; q++) begin
        rep[q]  = 1 + ((r + 3 * q) % 8);
        len[q]  = rep[q] + ((r + 3 * q + r * q) % (17 - rep[q]));
        off[q]  = (r * 3 + q * 5) % (17 - len[q]);
        cnt[q]  = 1 + ((r * 5 + q * 7) % 15);
        base[q] = (q * 16 + r * 3) % 64;
      end
      for (int e = 0; e < NS; e++) sched[e] = (r + e * (1 + r % 3)) % 4;
      cyc = 0; tickCnt = 0; ldE = 0; wTaken = 0; sndE = 0; sndV = 0;
      lastVecCyc = -10; doneCount = 0; overlapSeen = 1'b0;
      for (int e = 0; e < NS; e++) begin sentCnt[e] = 0; loadDone[e] = 1'b0; end
      monOn = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitCyc = 0;
      while (doneCount == 0 && waitCyc < 4000) begin
        @(negedge clk);
        waitCyc++;
      end
      repeat (4) @(negedge clk);
      check(doneCount == 1, "R10 single done per run", doneCount, 1);
      check(sndE == NS, "R6 all entries sent", sndE, NS);
      check(ldE == NS && wTaken == 0, "R2 words taken per entry", ldE, NS);
      check(tstReq == 1'b0, "R2 no request after run", tstReq, 0);
      if (cnt[sched[0]] > p + 6)
        check(overlapSeen, "R9 load overlapped sending", overlapSeen, 1);
      monOn = 1'b0;
      slowTick = 1'b0;
      @(negedge clk);
    end
    summary();
  end

endmodule